// File: doc/BRIEF.md
# Move-Only Transport-Triggered Processor Core

This core runs programs made of 8-bit instructions of exactly two kinds. A transfer copies one value from a bus source to a bus target. An immediate instruction shifts a 7-bit payload into an immediate register. The core has no separate jump, load, store or arithmetic opcodes. Each of these actions is a side effect of the source or target that a transfer names. Writing the program counter is a jump. Reading or writing the memory port is a load or a store. Writing the two operand latches feeds an adder and an unsigned comparator. Constants wider than 7 bits are built from successive immediate instructions, so the same program runs at any data width of 8 bits or more.

Each clock cycle the core executes one instruction. The instruction byte is read combinationally from the instruction port at the address on `imem_addr`. The data-memory port is also single-cycle: read data is combinational on `dmem_rdata` for the address in the address register, and a store is one cycle of `dmem_we`.

Control is a three-state machine. `ST_START` is the single idle cycle after reset, and its only transition leads to `ST_PLAIN`. `ST_PLAIN` means the previous instruction was not an immediate. `ST_CHAIN` means the previous instruction was an immediate. From both `ST_PLAIN` and `ST_CHAIN` the machine moves to `ST_CHAIN` on an immediate instruction. On any other instruction it moves to `ST_PLAIN`, including a conditional transfer that does not take effect. Reset returns the machine to `ST_START`.

Top module: `mover_core`

## Requirements
- R1: While reset is asserted and on leaving it, all internal registers are zero. This covers the program counter, address register, immediate register, both ALU operands and the general registers I, J, K. `imem_addr` is 0 and `dmem_we` is 0.
- R2: An instruction with bit 7 = 1 is an immediate instruction and carries a 7-bit payload in bits 6:0. When the previous instruction was not an immediate, the payload is loaded into the immediate register, zero-extended.
- R3: Each immediate instruction that directly follows another immediate instruction shifts the immediate register left by 7 and places the payload in bits 6:0. Bits shifted beyond the data width are lost.
- R4: Bits 7:6 = 00 is an unconditional transfer, with the source code in bits 5:3. The source codes are 0 = program counter, 1 = address register, 2 = memory data, 3 = immediate, 4 = ALU result, 5 = I, 6 = J, 7 = K.
- R5: The target code of a transfer is in bits 2:0. The target codes are 0 = program counter, 1 = address register, 2 = memory data, 3 = ALU operand A, 4 = ALU operand B, 5 = I, 6 = J, 7 = K.
- R6: Bits 7:6 = 01 is a conditional transfer. It takes effect only when the ALU flag is 1. When the flag is 0 it writes nothing, the program counter steps by one, and the following immediate starts a fresh load.
- R7: The program counter steps by one after every instruction unless a transfer that takes effect writes it. In that case the written value is the next fetch address. Reading the program counter yields the address of the instruction after the current one.
- R8: The memory data source returns `dmem_rdata` for the address register. A transfer to the memory data target asserts `dmem_we` for that one cycle, with the bus value on `dmem_wdata` and the address register on `dmem_addr`.
- R9: The ALU result source is (A + B) modulo 2^DATA_W. The ALU flag is 1 exactly when A < B as unsigned numbers.
- R10: No instruction executes in the first cycle after reset is released. The instruction at address 0 executes in the second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | DATA_W | Address of the instruction to execute |
| imem_data | input | 8 | Instruction byte at `imem_addr`, combinational |
| dmem_addr | output | DATA_W | Data-memory address, the address register |
| dmem_wdata | output | DATA_W | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_rdata | input | DATA_W | Read data at `dmem_addr`, combinational |

## Verification
The assertions assume that `imem_data` always holds a known byte for the current `imem_addr` and that `dmem_rdata` is combinationally valid for `dmem_addr` in the same cycle. The bench meets this with a 64-entry instruction array and a 16-word data array, both read combinationally. Every instruction slot is pre-filled with a harmless self-transfer of the program counter, and the bench drives no instruction stream of its own outside those arrays. Each generated program ends in a two-instruction loop, so fetches stay inside the array for the whole of each run.

// File: rtl/mover_pkg.sv
package mover_pkg;

    localparam int INSTR_W   = 8;
    localparam int CHUNK_W   = 7;
    localparam int GPR_N     = 3;
    localparam int GPR_BASE  = 5;

    typedef enum logic [2:0] {
        SRC_PC, SRC_ADDR, SRC_RAM, SRC_IMM, SRC_ALU, SRC_I, SRC_J, SRC_K
    } src_e;

    typedef enum logic [2:0] {
        DST_PC, DST_ADDR, DST_RAM, DST_OPA, DST_OPB, DST_I, DST_J, DST_K
    } dst_e;

    typedef enum logic [1:0] {
        K_MOVE, K_CMOV, K_IMM
    } kind_e;

    typedef enum logic [1:0] {
        ST_START, ST_PLAIN, ST_CHAIN
    } state_e;

endpackage

// File: rtl/mover_decode.sv
module mover_decode
    import mover_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output kind_e              kind,
    output src_e               src,
    output dst_e               dst,
    output logic [CHUNK_W-1:0] payload
);
    always_comb begin
        payload = instr[CHUNK_W-1:0];
        src     = src_e'(instr[5:3]);
        dst     = dst_e'(instr[2:0]);
        if (instr[7])
            kind = K_IMM;
        else if (instr[6])
            kind = K_CMOV;
        else
            kind = K_MOVE;
    end
endmodule

// File: rtl/mover_imm.sv
module mover_imm
    import mover_pkg::*;
#(
    parameter int W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               chain,
    input  logic [CHUNK_W-1:0] payload,
    output logic [W-1:0]       imm_q
);
    localparam int KEEP = W - CHUNK_W;

    always_ff @(posedge clk) begin
        if (!rst_n)
            imm_q <= '0;
        else if (load) begin
            if (chain)
                imm_q <= {imm_q[KEEP-1:0], payload};
            else
                imm_q <= {{KEEP{1'b0}}, payload};
        end
    end
endmodule

// File: rtl/mover_alu.sv
module mover_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] sum,
    output logic         lt
);
    always_comb begin
        sum = opa + opb;
        lt  = (opa < opb);
    end
endmodule

// File: rtl/mover_core.sv
module mover_core
    import mover_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [DATA_W-1:0]  imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic [DATA_W-1:0]  dmem_addr,
    output logic [DATA_W-1:0]  dmem_wdata,
    output logic               dmem_we,
    input  logic [DATA_W-1:0]  dmem_rdata
);
    localparam logic [DATA_W-1:0] PC_STEP = DATA_W'(1);

    state_e state_q, state_d;

    kind_e              kind;
    src_e               src;
    dst_e               dst;
    logic [CHUNK_W-1:0] payload;

    logic [DATA_W-1:0] pc_q, addr_q, opa_q, opb_q, imm_q;
    logic [DATA_W-1:0] pc_inc, bus, alu_sum;
    logic [DATA_W-1:0] gpr_q [GPR_N];
    logic              alu_lt;
    logic              exec_en, chain_mode, move_fire;

    mover_decode u_dec (
        .instr   (imem_data),
        .kind    (kind),
        .src     (src),
        .dst     (dst),
        .payload (payload)
    );

    mover_alu #(.W(DATA_W)) u_alu (
        .opa (opa_q),
        .opb (opb_q),
        .sum (alu_sum),
        .lt  (alu_lt)
    );

    assign exec_en    = (state_q != ST_START);
    assign chain_mode = (state_q == ST_CHAIN);
    assign move_fire  = exec_en && ((kind == K_MOVE) || ((kind == K_CMOV) && alu_lt));
    assign pc_inc     = pc_q + PC_STEP;

    mover_imm #(.W(DATA_W)) u_imm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (exec_en && (kind == K_IMM)),
        .chain   (chain_mode),
        .payload (payload),
        .imm_q   (imm_q)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START: state_d = ST_PLAIN;
            ST_PLAIN,
            ST_CHAIN: state_d = (kind == K_IMM) ? ST_CHAIN : ST_PLAIN;
            default:  state_d = ST_START;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_START;
        else
            state_q <= state_d;
    end

    // Source selection onto the shared bus
    always_comb begin
        unique case (src)
            SRC_PC:   bus = pc_inc;
            SRC_ADDR: bus = addr_q;
            SRC_RAM:  bus = dmem_rdata;
            SRC_IMM:  bus = imm_q;
            SRC_ALU:  bus = alu_sum;
            SRC_I:    bus = gpr_q[0];
            SRC_J:    bus = gpr_q[1];
            SRC_K:    bus = gpr_q[2];
            default:  bus = '0;
        endcase
    end

    // Outputs
    always_comb begin
        imem_addr  = pc_q;
        dmem_addr  = addr_q;
        dmem_wdata = bus;
        dmem_we    = move_fire && (dst == DST_RAM);
    end

    // Special registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            addr_q <= '0;
            opa_q  <= '0;
            opb_q  <= '0;
        end else if (exec_en) begin
            pc_q <= (move_fire && dst == DST_PC) ? bus : pc_inc;
            if (move_fire && dst == DST_ADDR) addr_q <= bus;
            if (move_fire && dst == DST_OPA)  opa_q  <= bus;
            if (move_fire && dst == DST_OPB)  opb_q  <= bus;
        end
    end

    // General registers I, J, K
    for (genvar g = 0; g < GPR_N; g++) begin : g_gpr
        localparam dst_e MY_DST = dst_e'(3'(GPR_BASE + g));
        always_ff @(posedge clk) begin
            if (!rst_n)
                gpr_q[g] <= '0;
            else if (move_fire && dst == MY_DST)
                gpr_q[g] <= bus;
        end
    end

endmodule

// File: rtl/mover_core_chk.sv
module mover_core_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] imem_addr,
    input logic [7:0]        imem_data,
    input logic              dmem_we,
    input logic              exec_en,
    input logic              chain_mode,
    input logic              alu_lt,
    input logic [DATA_W-1:0] imm_q
);
    // R8: a store only comes from a transfer naming the memory target
    assert_store_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (!imem_data[7] && imem_data[2:0] == 3'd2));

    // R10: nothing executes in the start cycle
    assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |-> !dmem_we);

    // R6: a skipped conditional transfer writes nothing
    assert_skip_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && imem_data[7:6] == 2'b01 && !alu_lt) |-> !dmem_we);

    // R6: a skipped conditional transfer steps the program counter
    assert_skip_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && imem_data[7:6] == 2'b01 && !alu_lt)
        |=> imem_addr == DATA_W'($past(imem_addr) + 1));

    // R7: an immediate instruction steps the program counter
    assert_imm_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && imem_data[7]) |=> imem_addr == DATA_W'($past(imem_addr) + 1));

    // R2: fresh immediate is the zero-extended payload
    assert_fresh_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && imem_data[7] && !chain_mode)
        |=> imm_q == {{(DATA_W-7){1'b0}}, $past(imem_data[6:0])});

    // R3: chained immediate keeps old low bits above the new payload
    assert_chain_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && imem_data[7] && chain_mode)
        |=> (imm_q[6:0] == $past(imem_data[6:0]) && imm_q[7] == $past(imm_q[0])));
endmodule

bind mover_core mover_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_we    (dmem_we),
    .exec_en    (exec_en),
    .chain_mode (chain_mode),
    .alu_lt     (alu_lt),
    .imm_q      (imm_q)
);

// File: tb/tb_mover_core.sv
`timescale 1ns/1ps
module tb_mover_core;
    localparam int W      = 16;
    localparam logic [15:0] FILL = 16'hA5A5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
    logic [7:0]    imem_data;
    logic          dmem_we;

    logic [7:0]    rom [0:63];
    logic [15:0]   mem [0:15];
    int            ptr;
    int            n_tests = 0;
    int            n_fail  = 0;
    bit            done    = 1'b0;

    always #4 clk = ~clk;

    assign imem_data  = rom[imem_addr[5:0]];
    assign dmem_rdata = mem[dmem_addr[3:0]];

    always @(posedge clk)
        if (dmem_we) mem[dmem_addr[3:0]] <= dmem_wdata;

    mover_core #(.DATA_W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] mv(int s, int d);
        return {2'b00, 3'(s), 3'(d)};
    endfunction
    function automatic logic [7:0] cmv(int s, int d);
        return {2'b01, 3'(s), 3'(d)};
    endfunction

    task automatic emit(logic [7:0] b);
        rom[ptr] = b;
        ptr++;
    endtask
    task automatic emit_const(logic [15:0] v);
        emit({1'b1, 5'd0, v[15:14]});
        emit({1'b1, v[13:7]});
        emit({1'b1, v[6:0]});
    endtask
    task automatic emit_halt();
        int h;
        h = ptr;
        emit({1'b1, 7'(h)});
        emit(mv(3, 0));
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) rom[i] = 8'h00;
        ptr = 0;
    endtask

    task automatic start_run();
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) mem[i] = FILL;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [6:0] chunk(int seed, int k);
        return 7'((seed * 37 + k * 53 + 11) & 127);
    endfunction

    initial begin
        // Immediate sweep: 1..4 chunks, several seeds
        for (int n = 1; n <= 4; n++) begin
            for (int seed = 0; seed < 12; seed++) begin
                logic [15:0] expv;
                clear_prog();
                emit(mv(7, 2));                  // K -> RAM at address 0
                expv = '0;
                for (int k = 0; k < n; k++) begin
                    emit({1'b1, chunk(seed, k)});
                    expv = (expv << 7) | 16'(chunk(seed, k));
                end
                emit(mv(3, 5));                  // IMM -> I
                emit(8'h83); emit(mv(3, 1)); emit(mv(5, 2));   // mem3 = I
                emit(mv(2, 7));                  // RAM -> K
                emit(8'h85); emit(mv(3, 1)); emit(mv(7, 2));   // mem5 = K
                emit(8'h86); emit(mv(3, 1)); emit(mv(1, 2));   // mem6 = ADDR
                emit_halt();

                rst_n = 1'b0;
                for (int i = 0; i < 16; i++) mem[i] = FILL;
                repeat (2) @(negedge clk);
                if (n == 1 && seed == 0) begin
                    check("R1 imem_addr in reset", imem_addr, 16'd0);
                    check("R1 dmem_we in reset", 16'(dmem_we), 16'd0);
                end
                rst_n = 1'b1;
                @(negedge clk);
                if (n == 1 && seed == 0) begin
                    check("R10 start cycle pc", imem_addr, 16'd0);
                    check("R1 addr after reset", dmem_addr, 16'd0);
                end
                @(negedge clk);
                if (n == 1 && seed == 0)
                    check("R10 first instr executed", imem_addr, 16'd1);
                repeat (40) @(negedge clk);
                check("R1 K reset zero stored", mem[0], 16'd0);
                if (n == 1) check("R2 fresh immediate", mem[3], expv);
                else        check("R3 chained immediate", mem[3], expv);
                check("R8 load then store", mem[5], expv);
                check("R4 ADDR source", mem[6], 16'd6);
            end
        end

        // ALU, flag, conditional transfer and PC sweep
        begin
            logic [15:0] vals [7];
            vals = '{16'h0000, 16'h0001, 16'h0007, 16'h007F, 16'h0080, 16'h1234, 16'hFFFF};
            for (int ia = 0; ia < 7; ia++) begin
                for (int ib = 0; ib < 7; ib++) begin
                    logic [15:0] a, b;
                    int lbl, pcst;
                    a = vals[ia];
                    b = vals[ib];
                    clear_prog();
                    emit_const(a); emit(mv(3, 3));
                    emit_const(b); emit(mv(3, 4));
                    emit_const(16'd1); emit(mv(3, 1)); emit(mv(4, 2));
                    emit_const(16'h0055); emit(mv(3, 6));
                    emit_const(16'd2); emit(mv(3, 1)); emit(cmv(6, 2));
                    lbl = ptr + 12;
                    emit_const(16'(lbl)); emit(cmv(3, 0));
                    emit_const(16'd3); emit(mv(3, 1));
                    emit_const(16'h0077); emit(mv(3, 2));
                    emit_const(16'd4); emit(mv(3, 1));
                    pcst = ptr;
                    emit(mv(0, 2));
                    emit_halt();

                    start_run();
                    repeat (70) @(negedge clk);
                    check("R9 sum", mem[1], 16'(a + b));
                    check("R6 cond store", mem[2], (a < b) ? 16'h0055 : FILL);
                    check("R7 cond jump", mem[3], (a < b) ? FILL : 16'h0077);
                    check("R7 PC source", mem[4], 16'(pcst + 1));
                end
            end
        end

        // R6: skipped conditional transfer breaks the immediate chain
        clear_prog();
        emit(8'h85);                 // IMM = 5
        emit(cmv(7, 5));             // flag 0 (A=B=0): skipped
        emit(8'h83);                 // fresh: IMM = 3
        emit(mv(3, 1));              // ADDR = 3
        emit(mv(1, 2));              // mem3 = 3
        emit_halt();
        start_run();
        repeat (20) @(negedge clk);
        check("R6 skip breaks chain", mem[3], 16'd3);
        check("R5 no stray write", mem[0], FILL);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule